// File: doc/BRIEF.md
# Table-Stride Tone Generator

This block makes a periodic tone by walking through one period of a 256-entry sine table. A 16-bit phase accumulator holds an 8-bit table index and 8 fractional bits. On every accepted sample tick it adds a programmable stride. A stride of n produces a tone of n × (tick rate / 256). At a 5 kHz tick rate, a stride of 1.0 gives about 19.5 Hz, and a stride of 13.41 gives a tone close to 262 Hz. The fractional stride bits let low notes keep their pitch instead of being rounded to whole steps. An integer mode is also available; it rounds the stride to the nearest whole step.

Each sample goes out on an 8-bit parallel DAC bus that has an active-low chip select and an active-low write strobe. The data word is loaded first. One clock later, both strobes are pulsed low together for exactly one clock. The DAC side has no back-pressure, so the timing is fixed rather than handshaked. A tick that arrives while a write is still in progress is dropped. While the enable is low, the phase is held at zero and nothing is written.

Top module: `tone_stride_gen`

## Requirements
- R1: After reset, `dac_data` is 0x80, `dac_cs_n` and `dac_wr_n` are high, and the phase is zero, so the first accepted tick emits table index 0.
- R2: The sample for table index k is 128 + round(127·sin(2πk/256)), which gives 0x80 at index 0, 255 at index 64 and 1 at index 192. The emitted index is the upper 8 bits of the phase as it was before that tick's advance.
- R3: Each accepted tick adds the effective stride to the 16-bit phase. The stride is unsigned, with 8 integer bits (15:8) and 8 fractional bits (7:0). The phase wraps modulo 65536, and fractional parts carry across ticks.
- R4: A stride above 64.0 (0x4000) is treated as exactly 64.0.
- R5: With `int_mode` high, the stride is first rounded to the nearest whole step (a fraction of 0x80 or more rounds up). The clamp of R4 is applied after the rounding.
- R6: A tick is accepted when it is sampled high while `enable` is high and no write is in progress. `dac_data` takes the new sample at that clock edge. `dac_cs_n` and `dac_wr_n` go low together at the following edge and return high one clock later.
- R7: A tick sampled during the two clocks of a write in progress is ignored. It does not advance the phase and it does not start a write.
- R8: While `enable` is low, the phase is cleared to zero, ticks are ignored, no strobe goes low, and `dac_data` keeps its value. A write that is in progress when enable drops is abandoned.
- R9: `dac_data` does not change while the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low clears the phase and stops writes |
| int_mode | input | 1 | Round the stride to a whole step |
| sample_tick | input | 1 | One-clock pulse at the sample rate |
| stride | input | 16 | Phase step, 8 integer bits and 8 fractional bits |
| dac_data | output | 8 | Sample word to the DAC |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_wr_n | output | 1 | DAC write strobe, active low |

## Verification
The assertions check the DAC strobes on every cycle. Chip select and write fall and rise together, a low pulse never lasts longer than one clock, the data word is frozen while the strobes are low, and any cycle with enable low is followed by a cycle with no write. Only the bench's scenarios can show that the right sample values appear, because that depends on the stride arithmetic over time. These scenarios cover fractional accumulation, wrap-around, clamping, integer rounding, dropped ticks during a write, and the restart at index 0 after a disable.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETUP  = 2'd1,
    SEQ_STROBE = 2'd2
  } seq_state_t;

  // Unsigned sine code: mid-scale offset plus a rounded scaled sine.
  function automatic int sine_code(input int k, input int depth, input int dw);
    real amp;
    real mid;
    real v;
    amp = real'((1 << (dw - 1)) - 1);
    mid = real'(1 << (dw - 1));
    v   = mid + amp * $sin(2.0 * 3.14159265358979 * real'(k) / real'(depth));
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/tone_step_shaper.sv
module tone_step_shaper #(
  parameter int IDX_W      = 8,
  parameter int FRAC_W     = 8,
  parameter int MAX_STRIDE = 64
) (
  input  logic [IDX_W+FRAC_W-1:0] stride_in,
  input  logic                    int_mode,
  output logic [IDX_W+FRAC_W-1:0] step_out
);
  localparam int ACC_W = IDX_W + FRAC_W;
  localparam logic [ACC_W:0] HALF     = (ACC_W+1)'(1) << (FRAC_W - 1);
  localparam logic [ACC_W:0] STEP_CAP = (ACC_W+1)'(MAX_STRIDE) << FRAC_W;

  logic [ACC_W:0] rounded;
  logic [ACC_W:0] picked;

  always_comb begin
    rounded = {1'b0, stride_in} + HALF;
    rounded[FRAC_W-1:0] = '0;
    picked = int_mode ? rounded : {1'b0, stride_in};
    if (picked > STEP_CAP) step_out = STEP_CAP[ACC_W-1:0];
    else                   step_out = picked[ACC_W-1:0];
  end
endmodule

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             advance,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (!enable) phase <= '0;
    else if (advance) phase <= phase + step;
  end
endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] sample
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int CODE = tone_pkg::sine_code(i, DEPTH, DATA_W);
    assign table_w[i] = DATA_W'(CODE);
  end

  assign sample = table_w[idx];
endmodule

// File: rtl/tone_dac_seq.sv
module tone_dac_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic [DATA_W-1:0] sample_in,
  output logic              accept,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_cs_n,
  output logic              dac_wr_n
);
  import tone_pkg::*;

  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  seq_state_t state;

  assign accept = enable && tick && (state == SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      dac_data <= MID;
      dac_cs_n <= 1'b1;
      dac_wr_n <= 1'b1;
    end else if (!enable) begin
      state    <= SEQ_IDLE;
      dac_cs_n <= 1'b1;
      dac_wr_n <= 1'b1;
    end else begin
      case (state)
        SEQ_IDLE: if (accept) begin
          dac_data <= sample_in;
          state    <= SEQ_SETUP;
        end
        SEQ_SETUP: begin
          dac_cs_n <= 1'b0;
          dac_wr_n <= 1'b0;
          state    <= SEQ_STROBE;
        end
        SEQ_STROBE: begin
          dac_cs_n <= 1'b1;
          dac_wr_n <= 1'b1;
          state    <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tone_stride_gen.sv
module tone_stride_gen #(
  parameter int IDX_W      = 8,
  parameter int FRAC_W     = 8,
  parameter int DATA_W     = 8,
  parameter int MAX_STRIDE = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    int_mode,
  input  logic                    sample_tick,
  input  logic [IDX_W+FRAC_W-1:0] stride,
  output logic [DATA_W-1:0]       dac_data,
  output logic                    dac_cs_n,
  output logic                    dac_wr_n
);
  localparam int ACC_W = IDX_W + FRAC_W;

  logic [ACC_W-1:0]  step_eff;
  logic [ACC_W-1:0]  phase;
  logic [DATA_W-1:0] rom_sample;
  logic              accept;

  tone_step_shaper #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .MAX_STRIDE(MAX_STRIDE)) u_shaper (
    .stride_in(stride), .int_mode(int_mode), .step_out(step_eff)
  );

  tone_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .advance(accept),
    .step(step_eff), .phase(phase)
  );

  tone_sine_rom #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rom (
    .idx(phase[ACC_W-1:FRAC_W]), .sample(rom_sample)
  );

  tone_dac_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(sample_tick),
    .sample_in(rom_sample), .accept(accept), .dac_data(dac_data),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n)
  );
endmodule

// File: rtl/tone_stride_chk.sv
module tone_stride_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_cs_n,
  input logic              dac_wr_n
);
  // R6
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n == dac_wr_n);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |=> dac_wr_n);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> $stable(dac_data));

  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> dac_wr_n);
endmodule

bind tone_stride_gen tone_stride_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .dac_data(dac_data),
  .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n)
);

// File: tb/tone_stride_gen_test.sv
module tone_stride_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        int_mode = 1'b0;
  logic        sample_tick = 1'b0;
  logic [15:0] stride = 16'h0100;
  logic [7:0]  dac_data;
  logic        dac_cs_n;
  logic        dac_wr_n;

  int checks = 0;
  int errors = 0;
  int model_phase = 0;

  always #2.5 clk = ~clk;

  tone_stride_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .int_mode(int_mode),
    .sample_tick(sample_tick), .stride(stride), .dac_data(dac_data),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sample(input int k);
    real v;
    v = 128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 256.0);
    return $rtoi(v + 0.5);
  endfunction

  function automatic int eff_step(input int s, input logic im);
    int t;
    t = s;
    if (im) t = ((s + 128) / 256) * 256;
    if (t > 16'h4000) t = 16'h4000;
    return t;
  endfunction

  // One accepted tick with full write timing check; extra ticks optional (R7)
  task automatic do_tick(input string tag, input bit pester);
    int exp_d;
    exp_d = exp_sample((model_phase >> 8) & 255);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = pester;
    check({tag, " R6 data loaded"}, dac_data, exp_d);
    check({tag, " R6 strobe high in setup"}, {dac_cs_n, dac_wr_n}, 2'b11);
    @(negedge clk);
    sample_tick = 1'b0 | pester;
    check({tag, " R6 strobes low"}, {dac_cs_n, dac_wr_n}, 2'b00);
    check({tag, " R9 data held"}, dac_data, exp_d);
    @(negedge clk);
    sample_tick = 1'b0;
    check({tag, " R6 strobes released"}, {dac_cs_n, dac_wr_n}, 2'b11);
    model_phase = (model_phase + eff_step(stride, int_mode)) & 16'hFFFF;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset data", dac_data, 8'h80);
    check("R1 reset strobes", {dac_cs_n, dac_wr_n}, 2'b11);
  endtask

  task automatic t_unit_stride();
    stride = 16'h0100;
    for (int i = 0; i < 4; i++) do_tick("R2 R3 unit stride", 1'b0);
  endtask

  task automatic t_fractional();
    stride = 16'h0D69;  // about 13.41 steps
    for (int i = 0; i < 6; i++) do_tick("R3 fractional", 1'b0);
  endtask

  task automatic t_clamp();
    enable = 1'b0; @(negedge clk); enable = 1'b1; model_phase = 0;
    stride = 16'h7F00;
    for (int i = 0; i < 5; i++) do_tick("R4 clamp R3 wrap", 1'b0);
  endtask

  task automatic t_int_mode();
    int_mode = 1'b1;
    stride = 16'h04BD;
    for (int i = 0; i < 3; i++) do_tick("R5 round 4.74", 1'b0);
    stride = 16'h0480;
    for (int i = 0; i < 2; i++) do_tick("R5 round tie", 1'b0);
    stride = 16'h047F;
    for (int i = 0; i < 2; i++) do_tick("R5 round down", 1'b0);
    stride = 16'h7F80;
    for (int i = 0; i < 2; i++) do_tick("R5 round then R4 clamp", 1'b0);
    int_mode = 1'b0;
  endtask

  task automatic t_busy_ticks();
    stride = 16'h0100;
    do_tick("R7 ticks during write", 1'b1);
    do_tick("R7 single advance", 1'b0);
  endtask

  task automatic t_disable();
    logic [7:0] held;
    held = dac_data;
    enable = 1'b0;
    @(negedge clk);
    sample_tick = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 no strobe while off", {dac_cs_n, dac_wr_n}, 2'b11);
      check("R8 data kept", dac_data, held);
    end
    sample_tick = 1'b0;
    enable = 1'b1;
    model_phase = 0;
    @(negedge clk);
    stride = 16'h0300;
    do_tick("R8 restart at index 0", 1'b0);
    do_tick("R8 restart second", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    @(negedge clk);
    t_unit_stride();
    t_fractional();
    t_clamp();
    t_int_mode();
    t_busy_ticks();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule